// File: doc/BRIEF.md
# CCD Frame Readout Sequencer

This block paces whole-frame readout of a charge-coupled imager built from a vertical (parallel) register and a horizontal (serial) register. While `run` is held high it runs frames back to back: an exposure phase, then row transfers into the serial register, each followed by that row's serial shifts and a sample strobe per shift, and finally a one-cycle end-of-frame pulse. Every shift is requested from an external phase sequencer. Each request stays high until the sequencer answers with a done pulse.

Two orderings are supported. In full-frame mode the exposed area is also the readout path, so the shutter output is high only during the exposure and goes low before the first row moves. In frame-transfer mode the controller first dumps every row into a shielded storage area with a burst of parallel shifts. It then reads the rows out of storage while the next exposure runs, and the shutter stays open. A dual-output option reads each row from both ends of the serial register at once, halving the serial shifts per row.

Configuration is captured when a frame sequence starts from idle and must stay constant until the block is idle again. Row count and column count must be at least one. In dual-output mode the column count must be even.

Top module: `ccd_readout_ctrl`

## Requirements
- R1: Within a frame, each row is read as exactly one parallel shift (`par_bulk`=0) followed by all of that row's serial shifts. A new parallel shift starts only after those serial shifts. `par_req` and `ser_req` are never high together.
- R2: Rows are strobed in ascending index order 0 to rows-1 on `samp_row`, and every row of the configured count is read in each frame.
- R3: In full-frame mode (`cfg_ft`=0), `shutter_open` is high for exactly I consecutive cycles per frame, where I is the exposure input with 0 treated as 1. It is low in every cycle in which a shift request is high.
- R4: In frame-transfer mode (`cfg_ft`=1), `shutter_open` is high in every cycle in which a shift request is high, so exposure continues through transfer and readout.
- R5: In frame-transfer mode, each frame starts with exactly rows back-to-back parallel shifts marked `par_bulk`=1, with no serial shift among them, before the first readout parallel shift.
- R6: In single-output mode (`cfg_dual`=0), each serial shift is followed by one strobe with `samp_col_a` running 0 to cols-1 in order and `samp_dual`=0.
- R7: In dual-output mode (`cfg_dual`=1), a row takes cols/2 serial shifts. Shift c strobes `samp_col_a`=c and `samp_col_b`=cols-1-c with `samp_dual`=1.
- R8: A shift request stays high until its done input is seen high. Each accepted done counts as exactly one shift.
- R9: `frame_done` is a single-cycle pulse in the cycle right after the strobe of the last pixel of the last row.
- R10: After reset, and while idle with `run` low, all outputs are 0. A frame that ends with `run` low returns to idle and issues no further requests.
- R11: In frame-transfer mode, the bulk transfer of the next frame starts more than I cycles after the cycle in which the previous bulk transfer's last done was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep producing frames while high |
| cfg_rows | input | ROW_W | Row count (1..MAX_ROWS) |
| cfg_cols | input | COL_W | Column count (1..MAX_COLS) |
| cfg_ft | input | 1 | 1 = frame-transfer, 0 = full-frame |
| cfg_dual | input | 1 | 1 = read each row from both serial ends |
| cfg_integ | input | INTEG_W | Exposure length in cycles (0 acts as 1) |
| par_req | output | 1 | Parallel shift request |
| par_bulk | output | 1 | Current parallel request is a bulk transfer into storage |
| par_done | input | 1 | Parallel shift completed |
| ser_req | output | 1 | Serial shift request |
| ser_done | input | 1 | Serial shift completed |
| shutter_open | output | 1 | High lets light reach the array |
| samp_valid | output | 1 | Output sample strobe |
| samp_dual | output | 1 | Second column index is valid |
| samp_row | output | ROW_W | Row of the strobed pixel(s) |
| samp_col_a | output | COL_W | Column on the first output |
| samp_col_b | output | COL_W | Column on the second output |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
The bench builds the block with MAX_ROWS=8, MAX_COLS=8 and INTEG_W=6. This makes the largest legal row and column counts usable in a short run, so the last-row and last-column wrap is exercised at full size. It also lets the exposure lengths reach the point where a frame-transfer readout ends before the next exposure does, which forces the wait path between frames. The sequencer's done latency is varied from zero to several cycles, so that back-to-back bulk transfers and held requests are both covered.

// File: rtl/ccd_rdo_pkg.sv
// Shared types for the CCD readout sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ccd_rdo_pkg;

    // Sequencer states; one state per visible phase of a frame.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_INTEG = 3'd1,
        ST_BULK  = 3'd2,
        ST_PAR   = 3'd3,
        ST_SER   = 3'd4,
        ST_SAMP  = 3'd5,
        ST_DONE  = 3'd6,
        ST_WAIT  = 3'd7
    } rdo_state_e;

endpackage

// File: rtl/ccd_integ_timer.sv
// Exposure timer. Counts cycles after a clear and saturates when the
// configured length has elapsed; `elapsed` stays high until the next clear.
// Assumes: lim is stable while counting (captured config).
module ccd_integ_timer #(
    parameter int INTEG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [INTEG_W-1:0] lim,
    output logic               elapsed
);
    logic [INTEG_W-1:0] cnt_q;
    logic [INTEG_W-1:0] lim_m1;

    // Last count value; a zero length behaves as one cycle.
    always_comb begin
        lim_m1 = (lim == '0) ? '0 : lim - INTEG_W'(1);
    end

    assign elapsed = (cnt_q == lim_m1);

    // Counter: restart on clear, otherwise advance until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (!elapsed) begin
            cnt_q <= cnt_q + INTEG_W'(1);
        end
    end

    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/ccd_pix_index.sv
// Row and serial-shift position tracker. Produces the row index and the
// one or two column indices of the current serial shift, plus last flags.
// Assumes: rows >= 1, cols >= 1, cols even when dual is set.
module ccd_pix_index #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_clr,
    input  logic             row_inc,
    input  logic             col_clr,
    input  logic             col_inc,
    input  logic [ROW_W-1:0] rows,
    input  logic [COL_W-1:0] cols,
    input  logic             dual,
    output logic [ROW_W-1:0] row,
    output logic [COL_W-1:0] col_a,
    output logic [COL_W-1:0] col_b,
    output logic             last_row,
    output logic             last_col
);
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] shifts;

    // Serial shifts needed per row for the selected output count.
    always_comb begin
        shifts = dual ? (cols >> 1) : cols;
    end

    // Row position: cleared at frame boundaries, advanced per row.
    always_ff @(posedge clk) begin
        if (!rst_n || row_clr) begin
            row_q <= '0;
        end else if (row_inc) begin
            row_q <= row_q + ROW_W'(1);
        end
    end

    // Shift position within the row.
    always_ff @(posedge clk) begin
        if (!rst_n || col_clr) begin
            col_q <= '0;
        end else if (col_inc) begin
            col_q <= col_q + COL_W'(1);
        end
    end

    assign row      = row_q;
    assign col_a    = col_q;
    assign col_b    = cols - COL_W'(1) - col_q;
    assign last_row = (row_q == rows - ROW_W'(1));
    assign last_col = (col_q == shifts - COL_W'(1));

    AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        row_inc |-> (row_q < rows - ROW_W'(1))); // R2
    AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (col_inc || col_clr) |-> (col_q < shifts)); // R6

endmodule

// File: rtl/ccd_readout_ctrl.sv
// Frame readout sequencer for a parallel + serial CCD register pair.
// Runs exposure, optional bulk transfer to storage, then row-by-row readout
// with one strobe per serial shift. All shifts use a req/done handshake.
// Assumes: config is stable from leaving idle until idle again; the phase
// sequencer raises done only while the matching request is high.
module ccd_readout_ctrl
    import ccd_rdo_pkg::*;
#(
    parameter int MAX_ROWS = 512,
    parameter int MAX_COLS = 512,
    parameter int INTEG_W  = 16,
    localparam int ROW_W   = $clog2(MAX_ROWS + 1),
    localparam int COL_W   = $clog2(MAX_COLS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [ROW_W-1:0]   cfg_rows,
    input  logic [COL_W-1:0]   cfg_cols,
    input  logic               cfg_ft,
    input  logic               cfg_dual,
    input  logic [INTEG_W-1:0] cfg_integ,
    output logic               par_req,
    output logic               par_bulk,
    input  logic               par_done,
    output logic               ser_req,
    input  logic               ser_done,
    output logic               shutter_open,
    output logic               samp_valid,
    output logic               samp_dual,
    output logic [ROW_W-1:0]   samp_row,
    output logic [COL_W-1:0]   samp_col_a,
    output logic [COL_W-1:0]   samp_col_b,
    output logic               frame_done
);
    rdo_state_e         state_q, state_d;
    logic [ROW_W-1:0]   rows_q;
    logic [COL_W-1:0]   cols_q;
    logic               ft_q, dual_q;
    logic [INTEG_W-1:0] integ_q;
    logic               elapsed, last_row, last_col;
    logic               tmr_clr, bulk_end;
    logic               row_clr, row_inc, col_clr, col_inc;
    logic [COL_W-1:0]   col_a, col_b;
    logic [ROW_W-1:0]   row;

    // Capture configuration when a run starts from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rows_q  <= '0;
            cols_q  <= '0;
            ft_q    <= 1'b0;
            dual_q  <= 1'b0;
            integ_q <= '0;
        end else if (state_q == ST_IDLE && run) begin
            rows_q  <= cfg_rows;
            cols_q  <= cfg_cols;
            ft_q    <= cfg_ft;
            dual_q  <= cfg_dual;
            integ_q <= cfg_integ;
        end
    end

    // Next-state decision for the frame sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run) state_d = ST_INTEG;
            ST_INTEG: if (elapsed) state_d = ft_q ? ST_BULK : ST_PAR;
            ST_BULK:  if (par_done && last_row) state_d = ST_PAR;
            ST_PAR:   if (par_done) state_d = ST_SER;
            ST_SER:   if (ser_done) state_d = ST_SAMP;
            ST_SAMP: begin
                if (!last_col)      state_d = ST_SER;
                else if (!last_row) state_d = ST_PAR;
                else                state_d = ST_DONE;
            end
            ST_DONE: begin
                if (!run)         state_d = ST_IDLE;
                else if (!ft_q)   state_d = ST_INTEG;
                else if (elapsed) state_d = ST_BULK;
                else              state_d = ST_WAIT;
            end
            ST_WAIT:  if (elapsed) state_d = ST_BULK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Counter commands derived from the current state and handshakes.
    always_comb begin
        bulk_end = (state_q == ST_BULK) && par_done && last_row;
        row_clr  = bulk_end || (state_q == ST_DONE) || (state_q == ST_IDLE);
        row_inc  = ((state_q == ST_BULK) && par_done && !last_row)
                || ((state_q == ST_SAMP) && last_col && !last_row);
        col_clr  = (state_q == ST_SAMP) && last_col;
        col_inc  = (state_q == ST_SAMP) && !last_col;
        tmr_clr  = ((state_d == ST_INTEG) && (state_q != ST_INTEG)) || bulk_end;
    end

    ccd_integ_timer #(.INTEG_W(INTEG_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .lim     (integ_q),
        .elapsed (elapsed)
    );

    ccd_pix_index #(.ROW_W(ROW_W), .COL_W(COL_W)) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_clr  (row_clr),
        .row_inc  (row_inc),
        .col_clr  (col_clr),
        .col_inc  (col_inc),
        .rows     (rows_q),
        .cols     (cols_q),
        .dual     (dual_q),
        .row      (row),
        .col_a    (col_a),
        .col_b    (col_b),
        .last_row (last_row),
        .last_col (last_col)
    );

    // Moore outputs decoded from the state.
    always_comb begin
        par_req      = (state_q == ST_PAR) || (state_q == ST_BULK);
        par_bulk     = (state_q == ST_BULK);
        ser_req      = (state_q == ST_SER);
        samp_valid   = (state_q == ST_SAMP);
        frame_done   = (state_q == ST_DONE);
        shutter_open = (state_q == ST_INTEG) || (ft_q && state_q != ST_IDLE);
        samp_dual    = samp_valid && dual_q;
        samp_row     = samp_valid ? row : '0;
        samp_col_a   = samp_valid ? col_a : '0;
        samp_col_b   = samp_dual ? col_b : '0;
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(par_req && ser_req)); // R1
    AST_FF_DARK_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ft_q && (par_req || ser_req)) |-> !shutter_open); // R3
    AST_FT_LIGHT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_q && (par_req || ser_req)) |-> shutter_open); // R4
    AST_BULK_NO_SERIAL: assert property (@(posedge clk) disable iff (!rst_n)
        par_bulk |-> !ser_req); // R5
    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (par_req && !par_done) |=> par_req); // R8
    AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_req && !ser_done) |=> ser_req); // R8
    AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(samp_valid)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R9
    AST_DUAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        samp_dual |-> (samp_col_a < samp_col_b)); // R7

endmodule

// File: tb/ccd_readout_ctrl_tb_top.sv
// Bench: event-queue reference model of the frame sequence, checked at
// every falling edge, plus per-cycle invariants for shutter and handshakes.
module ccd_readout_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MR = 8;
    localparam int MC = 8;
    localparam int IW = 6;
    localparam int RW = $clog2(MR + 1);
    localparam int CW = $clog2(MC + 1);

    typedef struct { int kind; int row; int a; int b; } ev_t;
    // kinds: 1 bulk shift, 2 readout parallel shift, 3 serial shift,
    //        4 sample strobe, 5 frame done

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [RW-1:0] cfg_rows = '0;
    logic [CW-1:0] cfg_cols = '0;
    logic cfg_ft = 1'b0, cfg_dual = 1'b0;
    logic [IW-1:0] cfg_integ = '0;
    logic par_req, par_bulk, ser_req, shutter_open, samp_valid, samp_dual, frame_done;
    logic par_done = 1'b0, ser_done = 1'b0;
    logic [RW-1:0] samp_row;
    logic [CW-1:0] samp_col_a, samp_col_b;

    int errs = 0, checks = 0;
    int lat = 0, pcnt = 0, scnt = 0;
    int cyc = 0;
    ev_t q[$];
    bit mon_en = 0;
    int done_cnt = 0;
    int exp_i = 1;
    bit cur_ft = 0;
    bit prev_samp = 0;
    int sh_run = 0;
    int last_bulk_cyc = -1;
    bit prev_bulk = 0;

    ccd_readout_ctrl #(.MAX_ROWS(MR), .MAX_COLS(MC), .INTEG_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run),
        .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_ft(cfg_ft),
        .cfg_dual(cfg_dual), .cfg_integ(cfg_integ),
        .par_req(par_req), .par_bulk(par_bulk), .par_done(par_done),
        .ser_req(ser_req), .ser_done(ser_done), .shutter_open(shutter_open),
        .samp_valid(samp_valid), .samp_dual(samp_dual), .samp_row(samp_row),
        .samp_col_a(samp_col_a), .samp_col_b(samp_col_b), .frame_done(frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Phase sequencer model: done after `lat` cycles of request, per shift.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (par_req) begin
            if (pcnt == lat) begin par_done = 1'b1; pcnt = 0; end
            else begin par_done = 1'b0; pcnt++; end
        end else begin par_done = 1'b0; pcnt = 0; end
        if (ser_req) begin
            if (scnt == lat) begin ser_done = 1'b1; scnt = 0; end
            else begin ser_done = 1'b0; scnt++; end
        end else begin ser_done = 1'b0; scnt = 0; end
    end

    function automatic ev_t mk(input int k, input int r, input int a, input int b);
        ev_t e;
        e.kind = k; e.row = r; e.a = a; e.b = b;
        return e;
    endfunction

    // Expected event list of one frame, written from the requirements.
    task automatic push_frame(input bit ft, input bit dual, input int rows, input int cols);
        int shifts;
        shifts = dual ? cols / 2 : cols;
        if (ft) for (int r = 0; r < rows; r++) q.push_back(mk(1, 0, 0, 0));   // R5
        for (int r = 0; r < rows; r++) begin                                   // R2
            q.push_back(mk(2, r, 0, 0));                                       // R1
            for (int c = 0; c < shifts; c++) begin
                q.push_back(mk(3, r, 0, 0));
                q.push_back(mk(4, r, c, dual ? cols - 1 - c : -1));            // R6 R7
            end
        end
        q.push_back(mk(5, 0, 0, 0));                                           // R9
    endtask

    task automatic pop_expect(input int kind, input int r, input int a, input int b,
                              input bit dual_f, input string req);
        ev_t e;
        if (q.size() == 0) begin
            check(0, req, kind, 0);
            return;
        end
        e = q.pop_front();
        check(e.kind == kind, req, kind, e.kind);
        if (e.kind == 4 && kind == 4) begin
            check(r == e.row, "R2", r, e.row);
            check(a == e.a, e.b < 0 ? "R6" : "R7", a, e.a);
            if (e.b < 0) check(!dual_f, "R6", dual_f, 0);
            else begin
                check(dual_f, "R7", dual_f, 1);
                check(b == e.b, "R7", b, e.b);
            end
        end
    endtask

    // Monitor: sampled at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            check(!(par_req && ser_req), "R1", int'(par_req && ser_req), 0);
            if (!cur_ft && (par_req || ser_req))
                check(!shutter_open, "R3", shutter_open, 0);
            if (cur_ft && (par_req || ser_req))
                check(shutter_open, "R4", shutter_open, 1);
            if (par_bulk && !prev_bulk && last_bulk_cyc >= 0)
                check(cyc - last_bulk_cyc > exp_i, "R11", cyc - last_bulk_cyc, exp_i + 1);
            prev_bulk = par_bulk;
            if (!cur_ft) begin
                if (shutter_open) sh_run++;
                else if (sh_run != 0) begin
                    check(sh_run == exp_i, "R3", sh_run, exp_i);
                    sh_run = 0;
                end
            end
            if (par_req && par_done) begin
                pop_expect(par_bulk ? 1 : 2, 0, 0, 0, 0, par_bulk ? "R5" : "R1");
                if (par_bulk) last_bulk_cyc = cyc;
            end
            if (ser_req && ser_done) pop_expect(3, 0, 0, 0, 0, "R8");
            if (samp_valid)
                pop_expect(4, int'(samp_row), int'(samp_col_a), int'(samp_col_b), samp_dual, "R6");
            if (frame_done) begin
                check(prev_samp, "R9", prev_samp, 1);
                pop_expect(5, 0, 0, 0, 0, "R9");
                done_cnt++;
            end
            prev_samp = samp_valid;
        end
    end

    task automatic run_case(input bit ft, input bit dual, input int rows, input int cols,
                            input int integ, input int latency, input int nframes);
        @(negedge clk);
        cfg_ft = ft; cfg_dual = dual; cfg_rows = RW'(rows);
        cfg_cols = CW'(cols); cfg_integ = IW'(integ);
        lat = latency; cur_ft = ft; exp_i = (integ == 0) ? 1 : integ;
        done_cnt = 0; sh_run = 0; last_bulk_cyc = -1; prev_bulk = 0; prev_samp = 0;
        for (int f = 0; f < nframes; f++) push_frame(ft, dual, rows, cols);
        run = 1'b1;
        // Drop run inside the last frame so its end returns to idle (R10).
        do begin @(negedge clk); #1; end while (done_cnt < nframes - 1 || !samp_valid);
        run = 1'b0;
        while (done_cnt < nframes) @(negedge clk);
        repeat (6) @(negedge clk);
        #1;
        check(q.size() == 0, "R2", q.size(), 0);
        check(!par_req && !ser_req && !shutter_open && !samp_valid && !frame_done,
              "R10", int'(par_req || ser_req || shutter_open || samp_valid || frame_done), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "watchdog", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // Reset state (R10)
        check(!par_req && !par_bulk && !ser_req && !shutter_open, "R10",
              int'(par_req || par_bulk || ser_req || shutter_open), 0);
        check(!samp_valid && !frame_done && samp_row == '0, "R10",
              int'(samp_valid || frame_done), 0);
        mon_en = 1;
        // Idle with run low: no activity at all (R10)
        cfg_rows = 4'd3; cfg_cols = 4'd4; cfg_integ = 6'd2;
        repeat (12) @(negedge clk);
        #1;
        check(!par_req && !ser_req && !shutter_open && !samp_valid, "R10",
              int'(par_req || ser_req || shutter_open || samp_valid), 0);
        check(q.size() == 0, "R10", q.size(), 0);

        run_case(0, 0, 3, 4, 5, 0, 1);   // full-frame single, zero latency
        run_case(0, 1, 2, 6, 0, 2, 2);   // full-frame dual, exposure 0 -> 1
        run_case(0, 1, 8, 8, 1, 1, 1);   // full size, dual
        run_case(1, 0, 3, 2, 40, 1, 2);  // frame-transfer, waits for exposure
        run_case(1, 1, 4, 4, 3, 0, 3);   // frame-transfer dual, back-to-back bulk
        run_case(1, 0, 1, 1, 2, 3, 2);   // single row, single column

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule